// File: doc/BRIEF.md
# Serial Sampling-Converter Interface Sequencer

This block is the digital timing side of a sampling serial converter. A host raises a convert-start input (`conv`) and supplies a serial bit clock (`sck`). Both are sampled on the local clock `clk` and are assumed to be synchronous to it. A rising edge on `conv` puts the internal sample/hold into hold and opens a 16-slot serial frame. Each rising `sck` edge then moves the frame one slot, most significant bit first. The word sent in a frame is always the result taken at the previous frame-starting convert edge. The result of the current conversion reaches the host one frame later. The parallel input `core_data` stands in for the analog converter core. The block captures it at each frame-starting convert edge.

The 16th rising `sck` edge ends the frame. The sample/hold returns to acquisition and the pad driver is released until the next convert edge. A normal cycle is 18 `sck` periods, which leaves two clocks of acquisition. The block has no power-down pin. Instead, the host pulses `conv` while keeping `sck` still. Two pulses enter a light power-down (nap) and four or more enter a deep power-down (sleep). Any `sck` transition wakes the block.

The sequencer has four states:
- ACQUIRE: sample mode, pad released.
- SHIFT: hold, frame in progress.
- NAP
- SLEEP

Transitions:
- Convert-start: any state to SHIFT, to NAP, or to SLEEP, depending on the convert-pulse count.
- Frame end: SHIFT to ACQUIRE on the 16th rise.
- Wake: NAP or SLEEP to ACQUIRE on an `sck` edge.

Top module: `serial_adc_timing`

## Requirements
- R1: After reset, `hold`, `sdo_drive`, `nap` and `sleep` are all 0.
- R2: A `conv` rise that starts a frame sets `hold` and `sdo_drive` to 1 in the `clk` cycle that samples the rise.
- R3: In 14-bit mode the frame has 16 slots. Slot k is shown on `sdo_bit` after k rising `sck` edges have followed the `conv` rise. Slots 0 and 1 carry 0, and slots 2 to 15 carry result bits 13 down to 0.
- R4: In 12-bit mode, slots 0 and 1 carry 0 and slots 2 to 13 carry result bits 11 down to 0. Slots 14 and 15 are don't-care.
- R5: The 16th rising `sck` edge clears `hold` and `sdo_drive`. Further `sck` edges before the next `conv` rise leave them at 0.
- R6: The word sent after a frame-starting `conv` rise is the `core_data` value captured at the previous frame-starting rise. Before any capture it is 0.
- R7: The block counts `conv` rises since the last `sck` edge. When the count reaches 2 or 3, it enters nap: `nap`=1, `hold`=0, `sdo_drive`=0, and no data is captured.
- R8: When that count reaches 4 or more, the block enters sleep: `sleep`=1 and `nap`=0, and no data is captured.
- R9: Any `sck` edge, rising or falling, leaves nap or sleep for acquisition and clears the pulse count.
- R10: A `conv` rise during a frame, with an `sck` edge since the previous rise, restarts the frame from slot 0 with the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial bit clock level |
| conv | input | 1 | Convert-start level |
| core_data | input | RES | Parallel result from the converter stand-in |
| sdo_bit | output | 1 | Serial data value |
| sdo_drive | output | 1 | Enable for the three-state serial pad |
| hold | output | 1 | 1 = hold, 0 = sample (acquisition) |
| nap | output | 1 | Light power-down active |
| sleep | output | 1 | Deep power-down active |

## Verification
Frames are read with data words of all ones, alternating bits and zero. These show whether bits are placed MSB first and whether the two leading slots stay zero. Random words with random acquisition lengths show that each frame carries the previous capture and not the current one. Convert-pulse trains of lengths one to six, with `sck` parked high or low, separate a conversion start from nap and from sleep. Waking from each power-down and then reading a frame shows that power-down pulses captured nothing. A restart in the middle of a frame shows that a convert edge preceded by an `sck` edge begins a new frame and does not count toward power-down.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_ACQUIRE,
        ST_SHIFT,
        ST_NAP,
        ST_SLEEP
    } seq_state_t;

    localparam int FRAME_SLOTS = 16;
    localparam int LEAD_SLOTS  = 2;
    localparam int NAP_PULSES   = 2;
    localparam int SLEEP_PULSES = 4;
endpackage

// File: rtl/level_tracker.sv
module level_tracker #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] lvl_q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else        lvl_q[g] <= lvl[g];
        end
    end
endmodule

// File: rtl/pd_pulse_counter.sv
module pd_pulse_counter #(
    parameter int NAP_AT   = 2,
    parameter int SLEEP_AT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_rise,
    input  logic sck_edge,
    output logic nap_hit,
    output logic sleep_hit
);
    localparam int CW = $clog2(SLEEP_AT + 1);
    localparam logic [CW-1:0] SAT = CW'(SLEEP_AT);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (sck_edge)
            cnt_d = conv_rise ? CW'(1) : '0;
        else if (conv_rise)
            cnt_d = (cnt_q >= SAT) ? SAT : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nap_hit   = conv_rise && (cnt_d >= CW'(NAP_AT));
    assign sleep_hit = conv_rise && (cnt_d >= SAT);
endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
    parameter int RES   = 14,
    parameter int SLOTS = 16,
    parameter int LEAD  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           shift,
    input  logic [RES-1:0] core_data,
    output logic           msb
);
    localparam int TAIL = SLOTS - LEAD - RES;

    logic [RES-1:0]   pend_q;
    logic [SLOTS-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            shreg_q <= '0;
        end else if (load) begin
            shreg_q <= SLOTS'(pend_q) << TAIL;
            pend_q  <= core_data;
        end else if (shift) begin
            shreg_q <= {shreg_q[SLOTS-2:0], 1'b0};
        end
    end

    assign msb = shreg_q[SLOTS-1];
endmodule

// File: rtl/serial_adc_timing.sv
module serial_adc_timing
    import adc_seq_pkg::*;
#(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sck,
    input  logic           conv,
    input  logic [RES-1:0] core_data,
    output logic           sdo_bit,
    output logic           sdo_drive,
    output logic           hold,
    output logic           nap,
    output logic           sleep
);
    localparam int SLOT_W = $clog2(FRAME_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

    initial begin
        if (RES != 12 && RES != 14)
            $error("RES must be 12 or 14");
    end

    logic [1:0] lvl_q;
    logic       sck_rise, sck_edge, conv_rise;
    logic       nap_hit, sleep_hit;
    logic       start, shift;

    seq_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;

    level_tracker #(.N(2)) u_levels (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({conv, sck}),
        .lvl_q (lvl_q)
    );

    assign sck_rise  = sck & ~lvl_q[0];
    assign sck_edge  = sck ^ lvl_q[0];
    assign conv_rise = conv & ~lvl_q[1];

    pd_pulse_counter #(
        .NAP_AT   (NAP_PULSES),
        .SLEEP_AT (SLEEP_PULSES)
    ) u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_rise (conv_rise),
        .sck_edge  (sck_edge),
        .nap_hit   (nap_hit),
        .sleep_hit (sleep_hit)
    );

    result_shifter #(
        .RES   (RES),
        .SLOTS (FRAME_SLOTS),
        .LEAD  (LEAD_SLOTS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .shift     (shift),
        .core_data (core_data),
        .msb       (sdo_bit)
    );

    // next-state and frame control
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        start   = 1'b0;
        shift   = 1'b0;
        if (conv_rise) begin
            if (sleep_hit)      state_d = ST_SLEEP;
            else if (nap_hit)   state_d = ST_NAP;
            else begin
                state_d = ST_SHIFT;
                slot_d  = '0;
                start   = 1'b1;
            end
        end else begin
            unique case (state_q)
                ST_ACQUIRE: state_d = ST_ACQUIRE;
                ST_SHIFT: begin
                    if (sck_rise) begin
                        shift = 1'b1;
                        if (slot_q == LAST_SLOT) state_d = ST_ACQUIRE;
                        else                     slot_d  = slot_q + SLOT_W'(1);
                    end
                end
                ST_NAP, ST_SLEEP: begin
                    if (sck_edge) state_d = ST_ACQUIRE;
                end
                default: state_d = ST_ACQUIRE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // output decode
    always_comb begin
        hold      = 1'b0;
        sdo_drive = 1'b0;
        nap       = 1'b0;
        sleep     = 1'b0;
        unique case (state_q)
            ST_ACQUIRE: ;
            ST_SHIFT: begin
                hold      = 1'b1;
                sdo_drive = 1'b1;
            end
            ST_NAP:   nap   = 1'b1;
            ST_SLEEP: sleep = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/serial_adc_timing_chk.sv
module serial_adc_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic sck_rise,
    input logic sck_edge,
    input logic conv_rise,
    input logic sdo_bit,
    input logic sdo_drive,
    input logic hold,
    input logic nap,
    input logic sleep
);
    // R3: the pad is only driven while the input is held
    assert_drive_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_drive |-> hold);

    // R3: a driven bit only changes on an sck rise or a new frame
    assert_bit_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_drive && !sck_rise && !conv_rise) |=> $stable(sdo_bit));

    // R7: power-down releases the pad and the hold
    assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nap || sleep) |-> (!hold && !sdo_drive));

    // R8: nap and sleep are exclusive
    assert_pd_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(nap && sleep));

    // R9: an sck edge with no convert rise leaves power-down
    assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_edge && !conv_rise) |=> (!nap && !sleep));
endmodule

bind serial_adc_timing serial_adc_timing_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_rise  (sck_rise),
    .sck_edge  (sck_edge),
    .conv_rise (conv_rise),
    .sdo_bit   (sdo_bit),
    .sdo_drive (sdo_drive),
    .hold      (hold),
    .nap       (nap),
    .sleep     (sleep)
);

// File: tb/test_serial_adc_timing.sv
module test_serial_adc_timing;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck_r = 1'b0;
    logic conv_r = 1'b0;
    logic [13:0] core14 = '0;
    logic [11:0] core12 = '0;

    logic a_bit, a_drv, a_hold, a_nap, a_sleep;
    logic b_bit, b_drv, b_hold, b_nap, b_sleep;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [13:0] m_pend14 = '0;
    logic [11:0] m_pend12 = '0;
    logic [13:0] m_word14;
    logic [11:0] m_word12;
    int  m_cnt = 0;
    bit  m_frame = 0;

    always #4 clk = ~clk;

    serial_adc_timing #(.RES(14)) i_serial_adc_timing (
        .clk(clk), .rst_n(rst_n), .sck(sck_r), .conv(conv_r),
        .core_data(core14), .sdo_bit(a_bit), .sdo_drive(a_drv),
        .hold(a_hold), .nap(a_nap), .sleep(a_sleep));

    serial_adc_timing #(.RES(12)) i_serial_adc_timing_12 (
        .clk(clk), .rst_n(rst_n), .sck(sck_r), .conv(conv_r),
        .core_data(core12), .sdo_bit(b_bit), .sdo_drive(b_drv),
        .hold(b_hold), .nap(b_nap), .sleep(b_sleep));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected bit of slot k; care=0 for don't-care slots
    function automatic logic exp_bit14(input logic [13:0] w, input int k);
        if (k < 2) return 1'b0;
        return w[15-k];
    endfunction

    function automatic logic exp_bit12(input logic [11:0] w, input int k, output bit care);
        care = (k < 14);
        if (k < 2 || k >= 14) return 1'b0;
        return w[13-k];
    endfunction

    function automatic int pd_code(input int cnt);
        if (cnt >= 4) return 2;
        if (cnt >= 2) return 1;
        return 0;
    endfunction

    task automatic tick(input logic s, input logic c);
        @(negedge clk);
        sck_r  = s;
        conv_r = c;
        @(posedge clk);
        #1;
    endtask

    task automatic toggle_sck();
        tick(~sck_r, conv_r);
        m_cnt = 0;
    endtask

    // one convert pulse; updates the model
    task automatic conv_pulse(input logic [13:0] d14, input logic [11:0] d12);
        core14 = d14;
        core12 = d12;
        tick(sck_r, 1'b1);
        m_cnt = (m_cnt >= 4) ? 4 : m_cnt + 1;
        if (m_cnt == 1) begin
            m_word14 = m_pend14;
            m_word12 = m_pend12;
            m_pend14 = d14;
            m_pend12 = d12;
            m_frame  = 1;
        end else begin
            m_frame = 0;
        end
        tick(sck_r, 1'b0);
    endtask

    task automatic check_pd_outputs(input string tag);
        int code = pd_code(m_cnt);
        chk({tag, " nap"},   a_nap,   code == 1);
        chk({tag, " sleep"}, a_sleep, code == 2);
        chk({tag, " drive"}, a_drv,   m_frame);
        chk({tag, " hold"},  a_hold,  m_frame);
        chk({tag, " nap12"}, b_nap,   code == 1);
    endtask

    // read slots from first to last-1, all 16 if full
    task automatic read_slots(input string tag, input int upto, input int extra);
        bit care;
        logic e12;
        if (sck_r) toggle_sck();
        for (int k = 0; k < upto; k++) begin
            chk({tag, " R2 drive"}, a_drv, 1);
            chk({tag, " R3 bit"}, a_bit, exp_bit14(m_word14, k));
            e12 = exp_bit12(m_word12, k, care);
            if (care) chk({tag, " R4 bit12"}, b_bit, e12);
            tick(1'b1, conv_r);
            m_cnt = 0;
            tick(1'b0, conv_r);
        end
        if (upto == 16) begin
            chk({tag, " R5 hold end"}, a_hold, 0);
            chk({tag, " R5 drive end"}, a_drv, 0);
            chk({tag, " R5 drive12 end"}, b_drv, 0);
            m_frame = 0;
            for (int j = 0; j < extra; j++) begin
                toggle_sck();
                toggle_sck();
            end
            chk({tag, " R5 extra clocks"}, a_hold + a_drv, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1403;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 hold", a_hold, 0);
        chk("R1 drive", a_drv, 0);
        chk("R1 nap", a_nap, 0);
        chk("R1 sleep", a_sleep, 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1'b0, 1'b0);
        chk("R1 after release", a_hold + a_drv + a_nap + a_sleep, 0);

        // first frame: word is zero
        conv_pulse(14'h3FFF, 12'hFFF);
        chk("R2 hold", a_hold, 1);
        chk("R6 first word zero", m_word14, 0);
        read_slots("R6 first", 16, 2);

        // directed patterns
        conv_pulse(14'h2AAA, 12'hAAA); read_slots("R3 ones", 16, 2);
        conv_pulse(14'h1555, 12'h555); read_slots("R3 alt", 16, 2);
        conv_pulse(14'h0000, 12'h000); read_slots("R3 alt2", 16, 2);
        conv_pulse(14'h2001, 12'h801); read_slots("R6 zero", 16, 1);
        conv_pulse(14'h0001, 12'h001); read_slots("R6 edge", 16, 0);

        // random frames
        for (int i = 0; i < 20; i++) begin
            conv_pulse(14'($urandom), 12'($urandom));
            read_slots("R6 rand", 16, $urandom_range(0, 3));
        end

        // R10 restart mid-frame
        conv_pulse(14'h1234, 12'h234);
        read_slots("R10 partial", 5, 0);
        conv_pulse(14'h0F0F, 12'h0F0);
        chk("R10 nap not entered", a_nap, 0);
        chk("R10 restart drive", a_drv, 1);
        read_slots("R10 restarted", 16, 2);

        // power-down trains, sck parked low or high
        for (int n = 1; n <= 6; n++) begin
            for (int lvl = 0; lvl < 2; lvl++) begin
                if (sck_r != lvl[0]) toggle_sck();
                toggle_sck();
                toggle_sck();
                for (int p = 0; p < n; p++)
                    conv_pulse(14'($urandom), 12'($urandom));
                if (n >= 4)      check_pd_outputs("R8 sleep");
                else if (n >= 2) check_pd_outputs("R7 nap");
                else             check_pd_outputs("R2 single");
                toggle_sck();
                chk("R9 wake nap", a_nap, 0);
                chk("R9 wake sleep", a_sleep, 0);
                if (n == 1) begin
                    m_frame = 0;
                    toggle_sck();
                    conv_pulse(14'($urandom), 12'($urandom));
                end else begin
                    conv_pulse(14'($urandom), 12'($urandom));
                end
                chk("R9 count cleared", a_drv, 1);
                read_slots("R7 no capture", 16, 2);
            end
        end

        // random power-down lengths
        for (int i = 0; i < 10; i++) begin
            int n = $urandom_range(1, 6);
            for (int p = 0; p < n; p++)
                conv_pulse(14'($urandom), 12'($urandom));
            if (n >= 2) check_pd_outputs("R8 rand pd");
            toggle_sck();
            m_frame = 0;
            toggle_sck();
            conv_pulse(14'($urandom), 12'($urandom));
            read_slots("R9 rand wake", 16, 2);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule